// File: doc/BRIEF.md
# Retriggerable Dual-Input One-Shot Timer

This block is a clocked, retriggerable monostable pulse generator. It watches three already-synchronised control levels: an active-low trigger, an active-high trigger and an active-low clear. When one of the allowed level changes appears, it drives a pulse on `q` that lasts a programmable number of clock cycles. This count stands in for an external resistor-capacitor time constant. `q_n` is always the complement of `q`.

All three inputs are sampled once per clock. An edge is found by comparing the present sample with the sample from the previous cycle, so the speed of an input transition does not matter. A pulse can start in three ways: the active-high trigger rises while the active-low trigger is low; the active-low trigger falls while the active-high trigger is high; or the clear returns high while both triggers are at their enabling levels. A new qualifying edge during a pulse reloads the full count, so a steady stream of triggers can hold `q` high without a gap. A low clear ends any pulse at once and blocks all triggering while it stays low.

Top module: `retrig_oneshot`

## Requirements
- R1: With `clr_n` high and `trig_lo` low, a 0-to-1 change of `trig_hi` sampled at a rising clock edge sets `q` high from that edge for exactly L cycles. L is the effective length (see R9).
- R2: With `clr_n` high and `trig_hi` high, a 1-to-0 change of `trig_lo` sampled at a clock edge sets `q` high from that edge for exactly L cycles.
- R3: A 0-to-1 change of `clr_n`, sampled while `trig_lo` is low and `trig_hi` is high, sets `q` high from that edge for exactly L cycles.
- R4: A qualifying edge sampled while a pulse is running reloads the count, so `q` stays high for L cycles after the last qualifying edge with no low cycle in between. A qualifying edge after the pulse has ended starts a fresh pulse.
- R5: While `clr_n` is low, `q` is 0 and `q_n` is 1 in the same cycle, without waiting for a clock edge. A pulse that is cut off this way does not resume when `clr_n` returns high, unless that return is itself a trigger under R3.
- R6: No pulse starts from `trig_hi` changing while `trig_lo` is high, or from `trig_lo` changing while `trig_hi` is low.
- R7: `q_n` equals the inverse of `q` at all times.
- R8: While `rst_n` is low, `q` is 0 and `q_n` is 1. The first sample after reset only records the input levels and never starts a pulse, whatever those levels are.
- R9: L is taken from `pulse_len` at the edge where the trigger is sampled. A value of 0 gives L = 1. A change of `pulse_len` during a pulse does not change that pulse.
- R10: A clear return and a trigger edge sampled at the same clock edge form one event, giving a single pulse of L cycles.
- R11: Holding the trigger levels steady after a pulse starts produces no further pulse. Once the count runs out, `q` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_lo | input | 1 | Active-low trigger level; its falling edge triggers while `trig_hi` is high |
| trig_hi | input | 1 | Active-high trigger level; its rising edge triggers while `trig_lo` is low |
| clr_n | input | 1 | Active-low clear; low forces the output idle, and its rise can trigger |
| pulse_len | input | CW | Pulse length in clock cycles, captured at each trigger (0 acts as 1) |
| q | output | 1 | Pulse output, high while the timer runs |
| q_n | output | 1 | Complement of `q` |

## Verification
Two functions of this block can meet in one cycle: the end of a clear and a trigger edge, and a reload landing inside a pulse that is already running. The bench provokes the first by releasing `clr_n` together with a falling `trig_lo` or a rising `trig_hi`, and expects exactly one pulse of L cycles. It provokes the second by placing a second trigger edge at every offset from two cycles into the pulse until just past its end. For each offset it computes the expected output cycle by cycle as the union of the first pulse window and a fresh L-cycle window, so any gap, stretch or lost reload shows up.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  localparam int unsigned PIN_W   = 3;
  localparam int unsigned IDX_LO  = 0;
  localparam int unsigned IDX_HI  = 1;
  localparam int unsigned IDX_CLR = 2;

  // Requested length of zero is promoted to a single cycle.
  function automatic logic [31:0] eff_len(input logic [31:0] req);
    return (req == 32'd0) ? 32'd1 : req;
  endfunction

  // Next value of the down-counter: clear wins, then reload, then decrement.
  function automatic logic [31:0] next_count(input logic [31:0] cur,
                                             input logic        clr_n,
                                             input logic        trig,
                                             input logic [31:0] len);
    if (!clr_n)             return 32'd0;
    else if (trig)          return len;
    else if (cur != 32'd0)  return cur - 32'd1;
    else                    return 32'd0;
  endfunction
endpackage

// File: rtl/os_edge_track.sv
module os_edge_track #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  output logic [W-1:0] prev,
  output logic         primed
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic hold_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_r <= 1'b0;
      else        hold_r <= cur[i];
    end
    assign prev[i] = hold_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end
endmodule

// File: rtl/os_trig_decode.sv
module os_trig_decode
  import oneshot_pkg::*;
(
  input  logic [PIN_W-1:0] cur,
  input  logic [PIN_W-1:0] prev,
  input  logic             primed,
  output logic             ev_hi_rise,
  output logic             ev_lo_fall,
  output logic             ev_clr_rise,
  output logic             trig
);
  logic lo_now, hi_now, clr_now;

  always_comb begin
    lo_now      = cur[IDX_LO];
    hi_now      = cur[IDX_HI];
    clr_now     = cur[IDX_CLR];
    ev_hi_rise  = hi_now & ~prev[IDX_HI] & ~lo_now;
    ev_lo_fall  = ~lo_now & prev[IDX_LO] & hi_now;
    ev_clr_rise = clr_now & ~prev[IDX_CLR] & ~lo_now & hi_now;
    trig        = primed & clr_now & (ev_hi_rise | ev_lo_fall | ev_clr_rise);
  end
endmodule

// File: rtl/os_pulse_timer.sv
module os_pulse_timer
  import oneshot_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_n,
  input  logic          trig,
  input  logic [CW-1:0] len,
  output logic [CW-1:0] cnt,
  output logic          running
);
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = CW'(next_count(32'(cnt), clr_n, trig, eff_len(32'(len))));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  assign running = (cnt != '0);
endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot
  import oneshot_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_lo,
  input  logic          trig_hi,
  input  logic          clr_n,
  input  logic [CW-1:0] pulse_len,
  output logic          q,
  output logic          q_n
);
  logic [PIN_W-1:0] pins_cur;
  logic [PIN_W-1:0] pins_prev;
  logic             primed;
  logic             ev_hi_rise, ev_lo_fall, ev_clr_rise;
  logic             trig_evt;
  logic [CW-1:0]    cnt;
  logic             running;

  always_comb begin
    pins_cur          = '0;
    pins_cur[IDX_LO]  = trig_lo;
    pins_cur[IDX_HI]  = trig_hi;
    pins_cur[IDX_CLR] = clr_n;
  end

  os_edge_track #(.W(PIN_W)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .cur    (pins_cur),
    .prev   (pins_prev),
    .primed (primed)
  );

  os_trig_decode u_dec (
    .cur         (pins_cur),
    .prev        (pins_prev),
    .primed      (primed),
    .ev_hi_rise  (ev_hi_rise),
    .ev_lo_fall  (ev_lo_fall),
    .ev_clr_rise (ev_clr_rise),
    .trig        (trig_evt)
  );

  os_pulse_timer #(.CW(CW)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_n   (clr_n),
    .trig    (trig_evt),
    .len     (pulse_len),
    .cnt     (cnt),
    .running (running)
  );

  // Clear acts without waiting for the counter to be flushed.
  assign q   = running & clr_n;
  assign q_n = ~q;
endmodule

// File: rtl/os_checker.sv
module os_checker (
  input logic clk,
  input logic rst_n,
  input logic clr_n,
  input logic trig_evt,
  input logic q,
  input logic q_n
);
  assert_reset_idle_R8: assert property (@(posedge clk)
    !rst_n |-> (!q && q_n));

  assert_clear_forces_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (!q && q_n));

  assert_complement_R7: assert property (@(posedge clk) disable iff (!rst_n)
    q_n == !q);

  // Covers the start of a pulse from any source (R1 R2 R3) and reload (R4).
  assert_trigger_raises_R1: assert property (@(posedge clk) disable iff (!rst_n)
    trig_evt |=> (q || !clr_n));

  assert_no_spurious_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_evt && !q) |=> !q);
endmodule

bind retrig_oneshot os_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clr_n    (clr_n),
  .trig_evt (trig_evt),
  .q        (q),
  .q_n      (q_n)
);

// File: tb/tb_retrig_oneshot.sv
`timescale 1ns/1ps
module tb_retrig_oneshot;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trig_lo = 1'b0;
  logic          trig_hi = 1'b1;
  logic          clr_n = 1'b1;
  logic [CW-1:0] pulse_len = 4'd3;
  logic          q, q_n;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  retrig_oneshot #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .trig_lo(trig_lo), .trig_hi(trig_hi),
    .clr_n(clr_n), .pulse_len(pulse_len), .q(q), .q_n(q_n)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s at %0t: actual %0b expected %0b", tag, $time, act, exp);
    end
  endtask

  task automatic check_out(input string tag, input logic exp_q);
    chk(tag, q, exp_q);
    chk("R7", q_n, ~exp_q);
  endtask

  function automatic int eff(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  task automatic go_idle();
    @(negedge clk);
    trig_lo = 1'b1; trig_hi = 1'b0; clr_n = 1'b1;
    for (int i = 0; i < 18; i++) @(negedge clk);
    check_out("R11", 1'b0);
  endtask

  // mode 0: trig_hi rise (R1), 1: trig_lo fall (R2), 2: clr_n rise (R3)
  task automatic pulse_run(input int mode, input int n);
    string tag;
    int    len;
    tag = (mode == 0) ? "R1" : (mode == 1) ? "R2" : "R3";
    len = eff(n);
    go_idle();
    if (mode == 0)      begin trig_lo = 1'b0; trig_hi = 1'b0; end
    else if (mode == 1) begin trig_lo = 1'b1; trig_hi = 1'b1; end
    else                begin trig_lo = 1'b0; trig_hi = 1'b1; clr_n = 1'b0; end
    pulse_len = CW'(n);
    @(negedge clk); check_out("R6", 1'b0);
    @(negedge clk); check_out("R6", 1'b0);
    if (mode == 0)      trig_hi = 1'b1;
    else if (mode == 1) trig_lo = 1'b0;
    else                clr_n = 1'b1;
    for (int c = 1; c <= len + 3; c++) begin
      @(negedge clk);
      check_out((c <= len) ? tag : "R11", (c <= len) ? 1'b1 : 1'b0);
      if (c == 1) pulse_len = 4'd15; // R9: mid-pulse change ignored
    end
  endtask

  // Second edge driven at negedge r; mode 0 via trig_hi, 1 via trig_lo.
  task automatic retrig_run(input int mode, input int n, input int r);
    logic e;
    go_idle();
    pulse_len = CW'(n);
    if (mode == 0) begin trig_lo = 1'b0; trig_hi = 1'b0; end
    else           begin trig_lo = 1'b1; trig_hi = 1'b1; end
    @(negedge clk); @(negedge clk);
    if (mode == 0) trig_hi = 1'b1; else trig_lo = 1'b0;
    for (int c = 1; c <= r + n + 2; c++) begin
      @(negedge clk);
      e = ((c <= n) || (c > r && c <= r + n)) ? 1'b1 : 1'b0;
      check_out("R4", e);
      if (c == r - 1) begin if (mode == 0) trig_hi = 1'b0; else trig_lo = 1'b1; end
      if (c == r)     begin if (mode == 0) trig_hi = 1'b1; else trig_lo = 1'b0; end
    end
  endtask

  task automatic clear_run(input int n, input int k);
    go_idle();
    pulse_len = CW'(n);
    trig_lo = 1'b0; trig_hi = 1'b0;
    @(negedge clk); @(negedge clk);
    trig_hi = 1'b1;
    for (int c = 1; c <= n + 3; c++) begin
      @(negedge clk);
      check_out("R5", (c <= k) ? 1'b1 : 1'b0);
      if (c == k) begin
        clr_n = 1'b0; trig_lo = 1'b1;
        #1 check_out("R5", 1'b0);
      end
      if (c == k + 1) clr_n = 1'b1;
    end
  endtask

  // mode 0: clear rise with trig_lo fall, 1: clear rise with trig_hi rise
  task automatic simul_run(input int mode, input int n);
    go_idle();
    pulse_len = CW'(n);
    clr_n = 1'b0;
    if (mode == 0) begin trig_lo = 1'b1; trig_hi = 1'b1; end
    else           begin trig_lo = 1'b0; trig_hi = 1'b0; end
    @(negedge clk); check_out("R5", 1'b0);
    @(negedge clk);
    clr_n = 1'b1;
    if (mode == 0) trig_lo = 1'b0; else trig_hi = 1'b1;
    for (int c = 1; c <= n + 3; c++) begin
      @(negedge clk);
      check_out("R10", (c <= n) ? 1'b1 : 1'b0);
    end
  endtask

  task automatic blocked_run();
    go_idle();
    pulse_len = 4'd3;
    trig_lo = 1'b1; trig_hi = 1'b0;
    @(negedge clk); trig_hi = 1'b1;              // rise while trig_lo high
    @(negedge clk); check_out("R6", 1'b0);
    @(negedge clk); trig_hi = 1'b0;
    @(negedge clk); trig_lo = 1'b0;              // fall while trig_hi low
    for (int i = 0; i < 3; i++) begin @(negedge clk); check_out("R6", 1'b0); end
    trig_lo = 1'b1; clr_n = 1'b0;
    @(negedge clk); clr_n = 1'b1;                // clear rise, triggers disabled
    for (int i = 0; i < 3; i++) begin @(negedge clk); check_out("R6", 1'b0); end
  endtask

  initial begin
    #1 check_out("R8", 1'b0);
    repeat (3) @(negedge clk);
    check_out("R8", 1'b0);
    rst_n = 1'b1;   // trigger-enabling levels present at first sample
    for (int i = 0; i < 4; i++) begin @(negedge clk); check_out("R8", 1'b0); end

    for (int m = 0; m < 3; m++)
      for (int n = 0; n <= 6; n++) pulse_run(m, n);
    for (int m = 0; m < 2; m++)
      for (int n = 2; n <= 5; n++)
        for (int r = 2; r <= n + 2; r++) retrig_run(m, n, r);
    for (int k = 1; k <= 5; k++) clear_run(5, k);
    for (int m = 0; m < 2; m++)
      for (int n = 1; n <= 4; n++) simul_run(m, n);
    blocked_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule